// File: doc/BRIEF.md
# Pixel Clock PLL Reprogramming Sequencer

This block changes the setting of a pixel clock PLL without letting the PLL run on a half-written value. A single start pulse captures two things: the present contents of the PLL control register and the new 32-bit setting. The block keeps a shadow copy of the register. It then performs five separate writes to the control register, with a fixed settle interval between the second and third writes. After the last write has been accepted, it pulses `done`.

The writes run in a fixed order. First the PLL is held in reset and bypassed. Next the new setting is merged into the register. The block then waits so that the loop control voltage can drain. After the wait it enables the PLL, releases reset, and finally removes the bypass. Every write is offered on a simple port of address, data and valid strobe. The write stays on the port until the register side returns ready. The settle time is a parameter counted in clock cycles. A chip uses a value near one millisecond, and a bench can use a short one.

Top module: `pll_prog_seq`

## Requirements
- R1: After reset `busy`, `wr_valid` and `done` are all low.
- R2: The first write goes to address `CTRL_ADDR`. Its data is the captured `cur_value` with bit 5 cleared and bits 31 (reset) and 8 (bypass) set.
- R3: The second write carries the first write's data ORed with the captured `pll_setting`, after bits 31, 11, 8 and 5 of that setting have been forced to zero.
- R4: Between acceptance of the second write and presentation of the third, `wr_valid` is low for exactly `SETTLE_CYCLES` cycles while `busy` stays high.
- R5: The third write is the second write's data with bit 11 (enable) set.
- R6: The fourth write is the third write's data with bit 31 cleared.
- R7: The fifth and last write is the fourth write's data with bit 8 cleared. Each run makes exactly five writes.
- R8: A write whose `wr_ready` is low stays on the port with the same address and data until it is accepted. The sequence does not advance in the meantime.
- R9: `busy` rises in the cycle after `start` is accepted and stays high until the final write is accepted. `done` is a single-cycle pulse in the first cycle with `busy` low.
- R10: A `start` pulse while `busy` is high is ignored. The running sequence and the values it captured are unchanged, and no second run follows.
- R11: `cur_value` and `pll_setting` are sampled only in the cycle `start` is accepted. Later changes to them do not alter the writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a reprogramming run (accepted when idle) |
| pll_setting | input | 32 | New PLL setting to merge in |
| cur_value | input | 32 | Present contents of the PLL control register |
| wr_addr | output | ADDR_W | Register address of the current write |
| wr_data | output | 32 | Data of the current write |
| wr_valid | output | 1 | A write is offered on the port |
| wr_ready | input | 1 | The register port accepts the offered write |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse after the final write is accepted |

## Verification
The shadow register and the step state are not visible directly, so any fault in them shows up on the write port. A wrong step or a mis-manipulated bit produces a wrong value on `wr_data` in the very write where it occurs. Because the shadow register carries each value into the next step, the error also appears in every later write of that run. A broken settle counter changes the length of the gap with `wr_valid` low in the one interval where it is allowed. A state machine that skips or repeats a step changes the number of accepted writes. It also shifts the cycle in which `done` pulses.

// File: rtl/pll_prog_seq.sv
module pll_prog_seq #(
  parameter int          ADDR_W        = 8,
  parameter logic [7:0]  CTRL_ADDR     = 8'h24,
  parameter int          SETTLE_CYCLES = 50000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [31:0]       pll_setting,
  input  logic [31:0]       cur_value,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [31:0]       wr_data,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic              busy,
  output logic              done
);

  localparam int CNT_W = (SETTLE_CYCLES < 2) ? 1 : $clog2(SETTLE_CYCLES);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETTLE_CYCLES - 1);

  localparam int BIT_RST = 31;
  localparam int BIT_EN  = 11;
  localparam int BIT_BYP = 8;
  localparam int BIT_AUX = 5;

  localparam logic [31:0] M_RST  = 32'(1) << BIT_RST;
  localparam logic [31:0] M_EN   = 32'(1) << BIT_EN;
  localparam logic [31:0] M_BYP  = 32'(1) << BIT_BYP;
  localparam logic [31:0] M_AUX  = 32'(1) << BIT_AUX;
  localparam logic [31:0] M_LOAD = ~(M_RST | M_EN | M_BYP | M_AUX);

  typedef enum logic [2:0] {
    ST_IDLE, ST_HOLD, ST_LOAD, ST_SETTLE, ST_ENABLE, ST_UNRST, ST_UNBYP
  } step_t;

  step_t            step;
  logic [31:0]      shadow;
  logic [31:0]      new_set;
  logic [CNT_W-1:0] cnt;

  wire writing = (step == ST_HOLD) || (step == ST_LOAD) || (step == ST_ENABLE) ||
                 (step == ST_UNRST) || (step == ST_UNBYP);
  wire fire    = writing && wr_ready;

  assign wr_valid = writing;
  assign wr_data  = shadow;
  assign wr_addr  = ADDR_W'(CTRL_ADDR);
  assign busy     = (step != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step    <= ST_IDLE;
      shadow  <= '0;
      new_set <= '0;
      cnt     <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (step)
        ST_IDLE: if (start) begin
          shadow  <= (cur_value & ~M_AUX) | M_RST | M_BYP;
          new_set <= pll_setting & M_LOAD;
          step    <= ST_HOLD;
        end
        ST_HOLD: if (fire) begin
          shadow <= shadow | new_set;
          step   <= ST_LOAD;
        end
        ST_LOAD: if (fire) begin
          cnt  <= '0;
          step <= ST_SETTLE;
        end
        ST_SETTLE: begin
          if (cnt == CNT_LAST) begin
            shadow <= shadow | M_EN;
            step   <= ST_ENABLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_ENABLE: if (fire) begin
          shadow <= shadow & ~M_RST;
          step   <= ST_UNRST;
        end
        ST_UNRST: if (fire) begin
          shadow <= shadow & ~M_BYP;
          step   <= ST_UNBYP;
        end
        ST_UNBYP: if (fire) begin
          done <= 1'b1;
          step <= ST_IDLE;
        end
        default: step <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pll_prog_seq_chk.sv
module pll_prog_seq_chk #(
  parameter int ADDR_W        = 8,
  parameter int SETTLE_CYCLES = 50000
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [31:0]       wr_data,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic              busy,
  input logic              done
);

  logic [31:0] gap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                gap <= '0;
    else if (!busy || wr_valid) gap <= '0;
    else                       gap <= gap + 1'b1;
  end

  AST_FIRST_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> wr_valid && wr_data[31] && wr_data[8] && !wr_data[5]); // R2

  AST_SETTLE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_valid) && !$rose(busy) |-> gap == 32'(SETTLE_CYCLES)); // R4

  AST_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_data) && $stable(wr_addr)); // R8

  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !(wr_valid && wr_ready) |=> busy); // R9

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && !wr_valid && $past(wr_valid && wr_ready)); // R9

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9

endmodule

bind pll_prog_seq pll_prog_seq_chk #(.ADDR_W(ADDR_W), .SETTLE_CYCLES(SETTLE_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_addr(wr_addr), .wr_data(wr_data),
  .wr_valid(wr_valid), .wr_ready(wr_ready), .busy(busy), .done(done)
);

// File: tb/test_pll_prog_seq.sv
module test_pll_prog_seq;
  localparam int N_SETTLE = 20;
  localparam int ADDR_W   = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [31:0] pll_set = '0;
  logic [31:0] cur_val = '0;
  logic [ADDR_W-1:0] wr_addr;
  logic [31:0] wr_data;
  logic wr_valid;
  logic wr_ready = 1'b1;
  logic busy, done;

  always #4 clk = ~clk;

  pll_prog_seq #(.ADDR_W(ADDR_W), .CTRL_ADDR(8'h24), .SETTLE_CYCLES(N_SETTLE)) i_pll_prog_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .pll_setting(pll_set), .cur_value(cur_val),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .busy(busy), .done(done)
  );

  int total = 0;
  int bad = 0;
  logic stall_mode = 1'b0;
  int stall_cnt = 0;
  logic [31:0] log_d [0:15];
  int log_n = 0;
  int gap_n = 0;
  int done_n = 0;
  int addr_bad = 0;
  int hold_bad = 0;
  int done_busy_bad = 0;
  logic prev_stall = 1'b0;
  logic [31:0] prev_d = '0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (stall_mode) begin
      stall_cnt++;
      wr_ready = (stall_cnt % 3 == 0);
    end else begin
      wr_ready = 1'b1;
    end
    if (prev_stall && (!wr_valid || wr_data !== prev_d)) hold_bad++;
    prev_stall = wr_valid && !wr_ready;
    prev_d = wr_data;
    if (wr_valid && wr_ready) begin
      if (log_n < 16) log_d[log_n] = wr_data;
      log_n++;
      if (wr_addr !== 8'h24) addr_bad++;
    end
    if (busy && !wr_valid) gap_n++;
    if (done) begin
      done_n++;
      if (busy) done_busy_bad++;
    end
  end

  function automatic logic [31:0] exp_w(input logic [31:0] c, input logic [31:0] s, input int k);
    logic [31:0] v;
    v = (c & ~32'h20) | 32'h8000_0100;
    if (k >= 1) v = v | (s & ~32'h8000_0920);
    if (k >= 2) v = v | 32'h800;
    if (k >= 3) v = v & ~32'h8000_0000;
    if (k >= 4) v = v & ~32'h100;
    return v;
  endfunction

  task automatic clear_log();
    log_n = 0; gap_n = 0; done_n = 0; addr_bad = 0; hold_bad = 0; done_busy_bad = 0;
  endtask

  task automatic pulse_start(input logic [31:0] c, input logic [31:0] s);
    @(negedge clk);
    cur_val = c; pll_set = s; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done();
    int t = 0;
    while (done_n == 0 && t < 2000) begin
      @(negedge clk);
      t++;
    end
    if (done_n == 0) begin
      total++; bad++;
      $display("FAIL R9 actual=no_done expected=done");
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic check_run(input string tag, input logic [31:0] c, input logic [31:0] s);
    chk({tag, " R7 write count"}, 32'(log_n), 32'd5);
    chk({tag, " R2 first write"}, log_d[0], exp_w(c, s, 0));
    chk({tag, " R3 load write"}, log_d[1], exp_w(c, s, 1));
    chk({tag, " R5 enable write"}, log_d[2], exp_w(c, s, 2));
    chk({tag, " R6 unreset write"}, log_d[3], exp_w(c, s, 3));
    chk({tag, " R7 unbypass write"}, log_d[4], exp_w(c, s, 4));
    chk({tag, " R2 address"}, 32'(addr_bad), 32'd0);
    chk({tag, " R4 settle gap"}, 32'(gap_n), 32'(N_SETTLE));
    chk({tag, " R9 done pulses"}, 32'(done_n), 32'd1);
    chk({tag, " R9 done with busy low"}, 32'(done_busy_bad), 32'd0);
    chk({tag, " R9 idle after"}, {30'd0, busy, wr_valid}, 32'd0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 reset state", {29'd0, busy, wr_valid, done}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", {29'd0, busy, wr_valid, done}, 32'd0);
  endtask

  task automatic t_basic();
    clear_log();
    pulse_start(32'h0000_0000, 32'h1234_5678);
    chk("R9 busy after start", {31'd0, busy}, 32'd1);
    wait_done();
    check_run("basic", 32'h0000_0000, 32'h1234_5678);
  endtask

  task automatic t_ones();
    clear_log();
    pulse_start(32'hFFFF_FFFF, 32'hFFFF_FFFF);
    wait_done();
    check_run("ones", 32'hFFFF_FFFF, 32'hFFFF_FFFF);
  endtask

  task automatic t_stall();
    clear_log();
    stall_mode = 1'b1;
    pulse_start(32'h0F0F_0A20, 32'h2710_C805);
    wait_done();
    stall_mode = 1'b0;
    check_run("stall", 32'h0F0F_0A20, 32'h2710_C805);
    chk("R8 held while stalled", 32'(hold_bad), 32'd0);
  endtask

  task automatic t_restart_ignored();
    clear_log();
    stall_mode = 1'b1;
    pulse_start(32'h0000_0020, 32'h3391_5801);
    pulse_start(32'hAAAA_5555, 32'h5555_AAAA);
    repeat (10) @(negedge clk);
    pulse_start(32'h1111_1111, 32'h2222_2222);
    wait_done();
    stall_mode = 1'b0;
    repeat (6) @(negedge clk);
    check_run("restart R10", 32'h0000_0020, 32'h3391_5801);
  endtask

  task automatic t_input_change();
    clear_log();
    pulse_start(32'h8000_0900, 32'h2308_8801);
    cur_val = 32'h0000_0000;
    pll_set = 32'hDEAD_BEEF;
    wait_done();
    check_run("inchange R11", 32'h8000_0900, 32'h2308_8801);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_basic();
    t_ones();
    t_stall();
    t_restart_ignored();
    t_input_change();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 100000);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule